// File: doc/BRIEF.md
# Sized add/subtract/compare execution unit

This unit is the integer add, subtract and compare stage of a CISC-style core. Each cycle in which `in_valid` is high, it decodes a 16-bit opcode word. It picks a destination and a source from a register operand, an effective-address (EA) operand, an immediate operand or a small constant held inside the opcode. It then adds, subtracts or compares them at byte, word or long width. One clock later it presents the following, registered:

- the merged result;
- a byte-lane write mask and a flag saying whether the register operand or the EA location receives it;
- the condition flags X, N, Z, V and C, with a per-flag update mask;
- an illegal-form indication;
- the base cycle count of the operation.

Four instruction forms are covered:

- the register form, in which a data register meets an EA operand in either direction;
- the immediate form;
- the quick form, with a 3-bit constant from 1 to 8;
- the address-register form, which always works on the whole 32-bit register.

The surrounding core computes effective addresses, performs memory access and adds the EA cost to the base count. It also commits the flags according to the update mask.

Top module: `sized_addsub_unit`

## Requirements
- R1: Opcode fields: bits 15:12 select the group. 1101 is add, 1001 is subtract, 1011 is compare, 0101 is quick (bit 8 = 0 add, 1 subtract), and 0000 is immediate when bit 8 = 0 and bits 11:9 are 011 (add), 010 (subtract) or 110 (compare). Bits 7:6 give the size: 00 byte, 01 word, 10 long. Bits 5:3 give the EA mode and bits 11:9 give the register or the quick constant. Outputs change only on the clock edge after `in_valid`. `out_valid` is high for exactly that one cycle, and the other outputs hold while no input is valid.
- R2: In the register form, bit 8 = 0 makes the register operand the destination (`wr_reg`), and bit 8 = 1 makes the EA operand the destination (`wr_ea`). Add yields destination + source and subtract yields destination − source.
- R3: For add and subtract, C and X both equal the carry (add) or borrow (subtract) out of the top bit of the selected width. `ccr_val` is ordered {X,N,Z,V,C} from bit 4 down to bit 0.
- R4: N is the top bit of the result at the selected width. Z is set when the result truncated to that width is zero. V is set on signed overflow at that width.
- R5: For byte and word operations to a register or EA destination, only the low 8 or 16 bits of `result` change. The upper bits are copied from the destination operand, and `lane_we` is 0001 (byte), 0011 (word) or 1111 (long).
- R6: Compare forms (register, immediate and address) compute destination − source. They set `ccr_upd` = 01111, so X is not updated, and they write nothing: `lane_we` = 0 and both write flags are low. The immediate compare uses the EA operand as its destination.
- R7: The quick form adds or subtracts the constant in bits 11:9, with 000 meaning 8.
- R8: A quick operation on EA mode 001 (address register) works on all 32 bits, writes `lane_we` = 1111 and updates no flag (`ccr_upd` = 0). A byte-size quick operation in mode 001 is illegal.
- R9: The address-register form (bits 7:6 = 11 in the add, subtract or compare group) has the register operand as destination. Bit 8 = 0 takes a word source, sign-extended to 32 bits, and bit 8 = 1 takes a long source. Add and subtract write all 32 bits and update no flag. Compare sets N, Z, V and C from the 32-bit difference.
- R10: Base cycles of the register form: a register destination costs 4 (byte or word) or 6 (long). An EA destination costs 8 or 12. Compare costs 4 or 6.
- R11: Base cycles of the immediate form. Add or subtract costs 8 or 16 in EA mode 000 and 12 or 20 otherwise. Compare costs 8 or 14 in mode 000 and 8 or 12 otherwise.
- R12: Base cycles of the quick form: 4 or 8 in modes 000 and 001, and 8 or 12 otherwise. The address-register form costs 8 (word add or subtract), 6 (long add or subtract) and 6 (compare).
- R13: The following are illegal:
  - any other opcode group;
  - size 11 in the quick or immediate forms;
  - an immediate form in mode 001;
  - a register-form compare with bit 8 = 1;
  - a register-form add or subtract with bit 8 = 1 in mode 000 or 001;
  - a byte-size quick operation in mode 001.

  An illegal form raises `illegal` and leaves `lane_we`, the write flags, `ccr_upd` and `base_cycles` at 0.
- R14: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 16 | Instruction word |
| reg_opnd | input | 32 | Register operand named by bits 11:9 |
| ea_opnd | input | 32 | Effective-address operand value |
| imm_opnd | input | 32 | Immediate operand (low 8 or 16 bits used for byte or word) |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Merged result value |
| lane_we | output | 4 | Byte-lane write mask |
| wr_reg | output | 1 | Result goes to the register operand |
| wr_ea | output | 1 | Result goes to the EA destination |
| ccr_val | output | 5 | Flag values {X,N,Z,V,C} |
| ccr_upd | output | 5 | Per-flag update mask, same order |
| illegal | output | 1 | Opcode is not a legal form of this class |
| base_cycles | output | 5 | Base cycle count, EA cost excluded |

## Verification
Directed operand pairs are applied at every width:

- Pairs that carry, borrow, overflow signed and truncate to zero separate the width-selection logic from the flag logic.
- Both directions of the register form show which operand ends up as destination and as minuend.
- Quick constants 0 and 3, and word address sources with bit 15 set, check the constant mapping and the sign extension.
- Each illegal encoding is applied once.

A long run of random opcodes from every group, with random operands, is then compared field by field against a behavioural model that uses wide signed integers. This exposes any mismatch in flag grouping, lane masks or cycle counts between forms.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    localparam int DW    = 32;
    localparam int LANES = DW / 8;
    localparam int CYC_W = 5;
    localparam int NFLAG = 5;

    typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_CMP} alu_op_e;
    typedef enum logic [1:0] {SZ_B = 2'b00, SZ_W = 2'b01, SZ_L = 2'b10} size_e;
    typedef enum logic [1:0] {SRC_EA, SRC_REG, SRC_IMM, SRC_QUICK} src_e;

    typedef struct packed {
        logic             legal;
        alu_op_e          op;
        size_e            sz;
        logic             dest_ea;
        logic             full;
        src_e             src;
        logic             sext_w;
        logic             upd_x;
        logic             upd_nzvc;
        logic [CYC_W-1:0] cyc;
    } dec_t;

    typedef struct packed {
        logic             valid;
        logic [DW-1:0]    result;
        logic [LANES-1:0] lane_we;
        logic             wr_reg;
        logic             wr_ea;
        logic [NFLAG-1:0] ccr_val;
        logic [NFLAG-1:0] ccr_upd;
        logic             illegal;
        logic [CYC_W-1:0] cyc;
    } out_t;
endpackage

// File: rtl/asu_decode.sv
module asu_decode
    import addsub_pkg::*;
(
    input  logic [15:0] opcode,
    output dec_t        dec
);
    logic [3:0] grp;
    logic [2:0] rfld;
    logic       dirb;
    logic [1:0] szf;
    logic [2:0] mode;
    logic       is_long;

    always_comb begin
        grp     = opcode[15:12];
        rfld    = opcode[11:9];
        dirb    = opcode[8];
        szf     = opcode[7:6];
        mode    = opcode[5:3];
        is_long = (szf == 2'b10);

        dec          = '0;
        dec.op       = OP_ADD;
        dec.sz       = SZ_B;
        dec.src      = SRC_EA;

        unique case (grp)
            4'hD, 4'h9, 4'hB: begin
                dec.op = (grp == 4'hD) ? OP_ADD : ((grp == 4'h9) ? OP_SUB : OP_CMP);
                if (szf == 2'b11) begin
                    // address-register form
                    dec.legal    = 1'b1;
                    dec.full     = 1'b1;
                    dec.sz       = dirb ? SZ_L : SZ_W;
                    dec.sext_w   = !dirb;
                    dec.upd_nzvc = (dec.op == OP_CMP);
                    dec.cyc      = (dec.op == OP_CMP || dirb) ? CYC_W'(6) : CYC_W'(8);
                end else begin
                    dec.sz = size_e'(szf);
                    if (dec.op == OP_CMP) begin
                        dec.legal    = !dirb;
                        dec.upd_nzvc = 1'b1;
                        dec.cyc      = is_long ? CYC_W'(6) : CYC_W'(4);
                    end else begin
                        dec.legal    = !(dirb && (mode <= 3'd1));
                        dec.dest_ea  = dirb;
                        dec.src      = dirb ? SRC_REG : SRC_EA;
                        dec.upd_x    = 1'b1;
                        dec.upd_nzvc = 1'b1;
                        if (dirb) dec.cyc = is_long ? CYC_W'(12) : CYC_W'(8);
                        else      dec.cyc = is_long ? CYC_W'(6)  : CYC_W'(4);
                    end
                end
            end
            4'h5: begin
                dec.op       = dirb ? OP_SUB : OP_ADD;
                dec.sz       = size_e'(szf);
                dec.src      = SRC_QUICK;
                dec.dest_ea  = 1'b1;
                dec.full     = (mode == 3'd1);
                dec.legal    = (szf != 2'b11) && !((mode == 3'd1) && (szf == 2'b00));
                dec.upd_x    = (mode != 3'd1);
                dec.upd_nzvc = (mode != 3'd1);
                if (mode <= 3'd1) dec.cyc = is_long ? CYC_W'(8)  : CYC_W'(4);
                else              dec.cyc = is_long ? CYC_W'(12) : CYC_W'(8);
            end
            4'h0: begin
                if (!dirb && (rfld == 3'b011 || rfld == 3'b010 || rfld == 3'b110)) begin
                    dec.op       = (rfld == 3'b011) ? OP_ADD : ((rfld == 3'b010) ? OP_SUB : OP_CMP);
                    dec.sz       = size_e'(szf);
                    dec.src      = SRC_IMM;
                    dec.dest_ea  = 1'b1;
                    dec.legal    = (szf != 2'b11) && (mode != 3'd1);
                    dec.upd_x    = (dec.op != OP_CMP);
                    dec.upd_nzvc = 1'b1;
                    if (dec.op == OP_CMP) begin
                        if (mode == 3'd0) dec.cyc = is_long ? CYC_W'(14) : CYC_W'(8);
                        else              dec.cyc = is_long ? CYC_W'(12) : CYC_W'(8);
                    end else begin
                        if (mode == 3'd0) dec.cyc = is_long ? CYC_W'(16) : CYC_W'(8);
                        else              dec.cyc = is_long ? CYC_W'(20) : CYC_W'(12);
                    end
                end
            end
            default: ;
        endcase

        if (!dec.legal) begin
            dec.upd_x    = 1'b0;
            dec.upd_nzvc = 1'b0;
            dec.cyc      = '0;
        end
    end
endmodule

// File: rtl/asu_alu.sv
module asu_alu
    import addsub_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  size_e         sz,
    output logic [DW-1:0] r,
    output logic          c,
    output logic          v,
    output logic          n,
    output logic          z
);
    localparam int NW = 3;

    logic [NW-1:0] cw, vw, nw, zw;
    logic [1:0]    sel;

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int W = 8 << g;
        logic [W:0] ext;
        assign ext   = sub ? ({1'b0, a[W-1:0]} - {1'b0, b[W-1:0]})
                           : ({1'b0, a[W-1:0]} + {1'b0, b[W-1:0]});
        assign cw[g] = ext[W];
        assign nw[g] = ext[W-1];
        assign zw[g] = (ext[W-1:0] == '0);
        assign vw[g] = sub ? ((a[W-1] != b[W-1]) && (ext[W-1] != a[W-1]))
                           : ((a[W-1] == b[W-1]) && (ext[W-1] != a[W-1]));
    end

    always_comb begin
        sel = (sz == SZ_B) ? 2'd0 : ((sz == SZ_W) ? 2'd1 : 2'd2);
        r   = sub ? (a - b) : (a + b);
        c   = cw[sel];
        v   = vw[sel];
        n   = nw[sel];
        z   = zw[sel];
    end
endmodule

// File: rtl/asu_lanes.sv
module asu_lanes
    import addsub_pkg::*;
(
    input  size_e            sz,
    output logic [LANES-1:0] lane,
    output logic [DW-1:0]    bitmask
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = (sz == SZ_L) || ((sz == SZ_W) && (i < 2)) || (i == 0);
        assign bitmask[8*i +: 8] = {8{lane[i]}};
    end
endmodule

// File: rtl/sized_addsub_unit.sv
module sized_addsub_unit
    import addsub_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [15:0]      opcode,
    input  logic [DW-1:0]    reg_opnd,
    input  logic [DW-1:0]    ea_opnd,
    input  logic [DW-1:0]    imm_opnd,
    output logic             out_valid,
    output logic [DW-1:0]    result,
    output logic [LANES-1:0] lane_we,
    output logic             wr_reg,
    output logic             wr_ea,
    output logic [NFLAG-1:0] ccr_val,
    output logic [NFLAG-1:0] ccr_upd,
    output logic             illegal,
    output logic [CYC_W-1:0] base_cycles
);
    dec_t             dec;
    logic [DW-1:0]    opa, opb, alu_r, bmask;
    logic [LANES-1:0] lmask;
    logic [3:0]       qval;
    size_e            alu_sz;
    logic             fc, fv, fn, fz, writes;
    out_t             st_d, st_q;

    asu_decode u_dec (.opcode(opcode), .dec(dec));

    always_comb begin
        qval   = (opcode[11:9] == 3'd0) ? 4'd8 : {1'b0, opcode[11:9]};
        opa    = dec.dest_ea ? ea_opnd : reg_opnd;
        alu_sz = dec.full ? SZ_L : dec.sz;
        unique case (dec.src)
            SRC_EA:    opb = dec.sext_w ? {{(DW-16){ea_opnd[15]}}, ea_opnd[15:0]} : ea_opnd;
            SRC_REG:   opb = reg_opnd;
            SRC_IMM:   opb = imm_opnd;
            SRC_QUICK: opb = {{(DW-4){1'b0}}, qval};
            default:   opb = ea_opnd;
        endcase
    end

    asu_alu u_alu (
        .a(opa), .b(opb), .sub(dec.op != OP_ADD), .sz(alu_sz),
        .r(alu_r), .c(fc), .v(fv), .n(fn), .z(fz)
    );

    asu_lanes u_lanes (.sz(alu_sz), .lane(lmask), .bitmask(bmask));

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        writes     = dec.legal && (dec.op != OP_CMP);
        if (in_valid) begin
            st_d.result  = (opa & ~bmask) | (alu_r & bmask);
            st_d.lane_we = writes ? lmask : '0;
            st_d.wr_reg  = writes && !dec.dest_ea;
            st_d.wr_ea   = writes && dec.dest_ea;
            st_d.ccr_val = {fc, fn, fz, fv, fc};
            st_d.ccr_upd = {dec.upd_x, {(NFLAG-1){dec.upd_nzvc}}};
            st_d.illegal = !dec.legal;
            st_d.cyc     = dec.cyc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign result      = st_q.result;
    assign lane_we     = st_q.lane_we;
    assign wr_reg      = st_q.wr_reg;
    assign wr_ea       = st_q.wr_ea;
    assign ccr_val     = st_q.ccr_val;
    assign ccr_upd     = st_q.ccr_upd;
    assign illegal     = st_q.illegal;
    assign base_cycles = st_q.cyc;
endmodule

// File: rtl/sized_addsub_unit_chk.sv
module sized_addsub_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [3:0]  lane_we,
    input logic        wr_reg,
    input logic        wr_ea,
    input logic [4:0]  ccr_val,
    input logic [4:0]  ccr_upd,
    input logic        illegal,
    input logic [4:0]  base_cycles
);
    AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R1
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(base_cycles))); // R1
    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(wr_reg && wr_ea)); // R2
    AST_X_TRACKS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ccr_upd[4]) |-> (ccr_val[4] == ccr_val[0])); // R3
    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ccr_upd[2] && ccr_val[2]) |-> !ccr_val[3]); // R4
    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((lane_we == 4'h0 || lane_we == 4'h1 || lane_we == 4'h3 || lane_we == 4'hF)
                       && ((wr_reg || wr_ea) == (lane_we != 4'h0)))); // R5
    AST_CMP_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && !wr_reg && !wr_ea) |-> (ccr_upd == 5'b01111)); // R6
    AST_FLAG_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ccr_upd == 5'b00000 || ccr_upd == 5'b01111 || ccr_upd == 5'b11111)); // R8
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (lane_we == 4'h0 && !wr_reg && !wr_ea
                                    && ccr_upd == 5'b0 && base_cycles == 5'd0)); // R13
endmodule

bind sized_addsub_unit sized_addsub_unit_chk u_chk (.*);

// File: tb/sized_addsub_unit_bench.sv
module sized_addsub_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic [31:0] reg_opnd = '0, ea_opnd = '0, imm_opnd = '0;
    logic        out_valid, wr_reg, wr_ea, illegal;
    logic [31:0] result;
    logic [3:0]  lane_we;
    logic [4:0]  ccr_val, ccr_upd, base_cycles;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // expected values from the model
    bit          e_ill, e_wreg, e_wea;
    logic [31:0] e_res;
    logic [3:0]  e_lane;
    logic [4:0]  e_ccv, e_ccu;
    int          e_cyc;
    string       e_ctag;

    always #5 clk = ~clk;

    sized_addsub_unit u_sized_addsub_unit (
        .clk, .rst_n, .in_valid, .opcode, .reg_opnd, .ea_opnd, .imm_opnd,
        .out_valid, .result, .lane_we, .wr_reg, .wr_ea, .ccr_val, .ccr_upd,
        .illegal, .base_cycles
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic longint sext16(input logic [31:0] x);
        return x[15] ? (longint'(x[15:0]) | 64'hFFFF_0000) : longint'(x[15:0]);
    endfunction

    function automatic void model(input logic [15:0] op, input logic [31:0] rv, ev, iv);
        int grp = int'(op[15:12]);
        int rf = int'(op[11:9]);
        int d = int'(op[8]);
        int sf = int'(op[7:6]);
        int md = int'(op[5:3]);
        int kind = 0;
        int bits = 32;
        bit full = 0, flg = 1;
        longint a = 0, b = 0, mask, half, ua, ub, sa, sb, ur, sr, rr;
        bit cy, vv, nn, zz;
        e_ill = 0; e_wea = 0; e_wreg = 0; e_cyc = 0; e_ctag = "R10";
        e_res = 'x; e_lane = 0; e_ccv = 0; e_ccu = 0;
        if (grp == 13 || grp == 9 || grp == 11) begin
            kind = (grp == 13) ? 0 : ((grp == 9) ? 1 : 2);
            if (sf == 3) begin
                full = 1; bits = 32; a = longint'(rv);
                b = d ? longint'(ev) : sext16(ev);
                flg = (kind == 2);
                e_cyc = (kind == 2 || d == 1) ? 6 : 8; e_ctag = "R12";
            end else if (kind == 2 && d == 1) e_ill = 1;
            else if (kind != 2 && d == 1 && md < 2) e_ill = 1;
            else begin
                bits = 8 << sf;
                e_wea = (d == 1);
                a = d ? longint'(ev) : longint'(rv);
                b = d ? longint'(rv) : longint'(ev);
                if (kind == 2) e_cyc = (sf == 2) ? 6 : 4;
                else if (d == 1) e_cyc = (sf == 2) ? 12 : 8;
                else e_cyc = (sf == 2) ? 6 : 4;
            end
        end else if (grp == 5) begin
            kind = d;
            if (sf == 3 || (md == 1 && sf == 0)) e_ill = 1;
            else begin
                full = (md == 1); flg = !full; bits = full ? 32 : (8 << sf);
                e_wea = 1; a = longint'(ev); b = (rf == 0) ? 8 : rf;
                if (md <= 1) e_cyc = (sf == 2) ? 8 : 4;
                else e_cyc = (sf == 2) ? 12 : 8;
                e_ctag = "R12";
            end
        end else if (grp == 0 && d == 0 && (rf == 3 || rf == 2 || rf == 6)) begin
            kind = (rf == 3) ? 0 : ((rf == 2) ? 1 : 2);
            if (sf == 3 || md == 1) e_ill = 1;
            else begin
                bits = 8 << sf; e_wea = 1; a = longint'(ev); b = longint'(iv);
                if (kind == 2) e_cyc = (md == 0) ? ((sf == 2) ? 14 : 8) : ((sf == 2) ? 12 : 8);
                else e_cyc = (md == 0) ? ((sf == 2) ? 16 : 8) : ((sf == 2) ? 20 : 12);
                e_ctag = "R11";
            end
        end else e_ill = 1;

        if (e_ill) begin e_wea = 0; e_cyc = 0; return; end
        if (kind == 2) e_wea = 0;
        e_wreg = (kind != 2) && !e_wea;

        mask = (longint'(1) << bits) - 1;
        half = longint'(1) << (bits - 1);
        ua = a & mask; ub = b & mask;
        sa = (ua >= half) ? ua - (mask + 1) : ua;
        sb = (ub >= half) ? ub - (mask + 1) : ub;
        if (kind == 0) begin ur = ua + ub; sr = sa + sb; cy = (ur > mask); end
        else begin ur = ua - ub; sr = sa - sb; cy = (ur < 0); end
        vv = (sr > half - 1) || (sr < -half);
        rr = ur & mask;
        nn = ((rr >> (bits - 1)) & 1) != 0;
        zz = (rr == 0);
        e_res = 32'(((a & ~mask) | rr) & 64'hFFFF_FFFF);
        if (kind != 2) e_lane = (bits == 32) ? 4'hF : ((bits == 16) ? 4'h3 : 4'h1);
        e_ccv = {cy, nn, zz, vv, cy};
        e_ccu = (kind == 2) ? 5'b01111 : (flg ? 5'b11111 : 5'b00000);
    endfunction

    task automatic run(input logic [15:0] op, input logic [31:0] rv, ev, iv, input string tag);
        model(op, rv, ev, iv);
        @(negedge clk);
        opcode = op; reg_opnd = rv; ea_opnd = ev; imm_opnd = iv; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "out_valid", longint'(out_valid), 1);
        chk("R13", "illegal", longint'(illegal), longint'(e_ill));
        chk("R13", "lane_we", longint'(lane_we), longint'(e_lane));
        chk("R2", "wr_reg", longint'(wr_reg), longint'(e_wreg));
        chk("R2", "wr_ea", longint'(wr_ea), longint'(e_wea));
        chk(tag, "ccr_upd", longint'(ccr_upd), longint'(e_ccu));
        chk(e_ctag, "base_cycles", longint'(base_cycles), longint'(e_cyc));
        if (!e_ill) begin
            chk(tag, "result", longint'(result), longint'(e_res));
            chk(tag, "flags", longint'(ccr_val & e_ccu), longint'(e_ccv & e_ccu));
        end
        @(negedge clk);
        chk("R1", "valid drop", longint'(out_valid), 0);
        if (!e_ill) chk("R1", "result hold", longint'(result), longint'(e_res));
    endtask

    function automatic logic [15:0] enc(input logic [3:0] g, input logic [2:0] r,
                                        input logic dbit, input logic [1:0] s,
                                        input logic [2:0] m, input logic [2:0] e);
        return {g, r, dbit, s, m, e};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14: reset state
        chk("R14", "out_valid", longint'(out_valid), 0);
        chk("R14", "result", longint'(result), 0);
        chk("R14", "ccr_upd", longint'(ccr_upd), 0);
        chk("R14", "base_cycles", longint'(base_cycles), 0);
        rst_n = 1'b1;

        // R3/R4/R5 register form, register destination
        run(enc(4'hD, 3'd0, 1'b0, 2'b00, 3'd0, 3'd1), 32'h1234_5678, 32'h0000_00F0, 0, "R3");
        run(enc(4'hD, 3'd0, 1'b0, 2'b01, 3'd2, 3'd1), 32'hABCD_7FFF, 32'h0000_0001, 0, "R4");
        run(enc(4'hD, 3'd0, 1'b0, 2'b10, 3'd2, 3'd1), 32'hFFFF_FFFF, 32'h0000_0001, 0, "R4");
        run(enc(4'h9, 3'd0, 1'b0, 2'b00, 3'd0, 3'd1), 32'h5555_5510, 32'h0000_0020, 0, "R5");
        run(enc(4'h9, 3'd0, 1'b0, 2'b01, 3'd3, 3'd1), 32'h0000_8000, 32'h0000_0001, 0, "R4");
        // R2 EA destination, destination minus source
        run(enc(4'h9, 3'd0, 1'b1, 2'b01, 3'd2, 3'd1), 32'h0000_0030, 32'hCAFE_0100, 0, "R2");
        run(enc(4'hD, 3'd0, 1'b1, 2'b10, 3'd2, 3'd1), 32'h8000_0000, 32'h8000_0000, 0, "R2");
        // R6 compares
        run(enc(4'hB, 3'd0, 1'b0, 2'b10, 3'd0, 3'd1), 32'h1234_5678, 32'h1234_5678, 0, "R6");
        run(enc(4'hB, 3'd0, 1'b0, 2'b00, 3'd0, 3'd1), 32'h0000_0001, 32'h0000_0002, 0, "R6");
        run(enc(4'h0, 3'b110, 1'b0, 2'b10, 3'd0, 3'd0), 0, 32'h0000_0005, 32'h0000_0007, "R6");
        run(enc(4'h0, 3'b110, 1'b0, 2'b00, 3'd2, 3'd0), 0, 32'h0000_0080, 32'h0000_0001, "R6");
        // R9 address-register forms
        run(enc(4'hD, 3'd0, 1'b0, 2'b11, 3'd0, 3'd1), 32'h0000_1000, 32'h0000_FFFE, 0, "R9");
        run(enc(4'h9, 3'd0, 1'b1, 2'b11, 3'd0, 3'd1), 32'h0000_1000, 32'h0000_2000, 0, "R9");
        run(enc(4'hB, 3'd0, 1'b0, 2'b11, 3'd0, 3'd1), 32'hFFFF_8000, 32'h0000_8000, 0, "R9");
        // R7/R8 quick forms
        run(enc(4'h5, 3'd0, 1'b0, 2'b00, 3'd0, 3'd1), 32'h0, 32'h0000_00FA, 0, "R7");
        run(enc(4'h5, 3'd3, 1'b1, 2'b10, 3'd2, 3'd1), 32'h0, 32'h0000_0002, 0, "R7");
        run(enc(4'h5, 3'd3, 1'b1, 2'b01, 3'd1, 3'd1), 32'h0, 32'h0001_0001, 0, "R8");
        run(enc(4'h5, 3'd1, 1'b0, 2'b00, 3'd1, 3'd1), 32'h0, 32'h0000_0001, 0, "R8");
        // R11 immediate add/sub
        run(enc(4'h0, 3'b011, 1'b0, 2'b10, 3'd0, 3'd0), 0, 32'h7FFF_FFFF, 32'h0000_0001, "R11");
        run(enc(4'h0, 3'b010, 1'b0, 2'b01, 3'd5, 3'd0), 0, 32'h1111_0000, 32'h0000_0001, "R11");
        // R10 register-form cycles to memory
        run(enc(4'hD, 3'd2, 1'b1, 2'b00, 3'd3, 3'd4), 32'h0000_0001, 32'h0000_00FF, 0, "R10");
        // R13 illegal encodings
        run(16'hFFFF, 0, 0, 0, "R13");
        run(enc(4'hB, 3'd0, 1'b1, 2'b00, 3'd0, 3'd0), 0, 0, 0, "R13");
        run(enc(4'hD, 3'd0, 1'b1, 2'b00, 3'd0, 3'd0), 0, 0, 0, "R13");
        run(enc(4'h0, 3'b011, 1'b0, 2'b11, 3'd0, 3'd0), 0, 0, 0, "R13");
        run(enc(4'h0, 3'b010, 1'b0, 2'b01, 3'd1, 3'd0), 0, 0, 0, "R13");
        run(enc(4'h5, 3'd2, 1'b0, 2'b11, 3'd0, 3'd0), 0, 0, 0, "R13");

        // random mix compared against the model
        for (int i = 0; i < 400; i++) begin
            logic [15:0] op;
            logic [31:0] rv, ev, iv;
            op = 16'($urandom);
            case ($urandom_range(0, 4))
                0: op[15:12] = 4'hD;
                1: op[15:12] = 4'h9;
                2: op[15:12] = 4'hB;
                3: op[15:12] = 4'h5;
                default: begin
                    op[15:12] = 4'h0;
                    case ($urandom_range(0, 3))
                        0: op[11:9] = 3'b011;
                        1: op[11:9] = 3'b010;
                        2: op[11:9] = 3'b110;
                        default: ;
                    endcase
                end
            endcase
            rv = $urandom; ev = $urandom; iv = $urandom;
            if (i % 7 == 0) ev = rv;
            if (i % 11 == 0) rv = 32'h8000_7F80;
            run(op, rv, ev, iv, "R4");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule